// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The combiner collects level-sensitive interrupt source lines into groups of eight and reduces each group to a single request line for a downstream interrupt controller. Source line n maps to group n>>3, bit n&7. A group's request is high while at least one of its sources is both high and enabled. Each group keeps an 8-bit enable mask. Software changes the mask through a write-one-to-set word and a write-one-to-clear word.

Software sees four 32-bit words per 16-byte address window. Each window covers four consecutive groups, one byte lane per group. Two of the words are read-only: one gives the raw source levels and one gives the levels after masking. A two-word summary at offsets 0x100 and 0x104 shows the registered group outputs.

A parameter sets how many groups accept sources at all. Sources above that limit are ignored. A write to a read-only location has no effect on any state and raises a one-cycle flag.

Top module: `irq_combiner_top`

## Requirements
- R1: Source line n appears as bit n&7 of the byte for group n>>3. Group g sits in window g>>2, in byte lane g&3 (bits 8k+7..8k for lane k) of every word of that window.
- R2: A write to word 0 of a window (offset 16w+0x0) ORs each written 1 into the matching group mask bit. A 0 bit leaves that mask bit unchanged.
- R3: A write to word 1 of a window (offset 16w+0x4) clears each mask bit written as 1. A 0 bit leaves that mask bit unchanged.
- R4: Word 2 (offset 16w+0x8) reads the current raw source levels of the window's four groups. Nothing is latched: a bit reads 0 as soon as its line is low.
- R5: Word 3 (offset 16w+0xC) reads the raw levels ANDed with the current masks.
- R6: Group output g is registered. After a clock edge it equals the OR over the group's 8 bits of (mask & level). The mask used includes any mask write taken at that edge, and the levels are those sampled at that edge.
- R7: The word at 0x100 holds group outputs 0..31 in bit g. The word at 0x104 holds groups 32..63 in bit g-32. Bits for groups that do not exist read 0.
- R8: Reading word 0 or word 1 returns the last value written to that word, not the mask. After reset these words read 0, except at 0xC0, 0xC4, 0xD0 and 0xD4, which read 0x01010101.
- R9: A write to word 2 or word 3 of any window, or to 0x100..0x107, changes no state. `bad_wr_o` is high for exactly the one cycle after such a write and is low otherwise.
- R10: For group index g >= SRC_GROUPS, the group's sources are ignored: its raw bits read 0 and its output stays low whatever the mask.
- R11: Reset clears every mask bit and output, so masked status reads 0 even while sources are high. A read of an unmapped offset (0x108..0x1FF) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 8*NUM_GROUPS | Level-sensitive source lines |
| bus_addr_i | input | 9 | Byte offset of the register access |
| bus_wr_i | input | 1 | Write strobe, one access per cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | NUM_GROUPS | Registered group request lines |
| bad_wr_o | output | 1 | One-cycle pulse after a write to a read-only location |

## Verification
Two things can land in the same clock edge: a mask write and a change in a source level. A set write can coincide with a source rising, and a clear write can coincide with a source falling. Both cases are provoked directly, and they recur many times in a long random phase. In every case the output seen after the edge must reflect both the new mask and the new level together, with no intermediate value for one cycle. A behavioural model applies the write and then samples the levels at each edge, and it is compared against every output and against the read data on every cycle.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int LANE_W      = 8;
  localparam int GRP_PER_WIN = 4;
  localparam int DATA_W      = LANE_W * GRP_PER_WIN;
  localparam int ADDR_W      = 9;
  localparam logic [DATA_W-1:0] HOLD_PRESET = 32'h0101_0101;

  typedef enum logic [1:0] {
    W_SET = 2'd0,
    W_CLR = 2'd1,
    W_RAW = 2'd2,
    W_MSK = 2'd3
  } word_e;

  function automatic logic [DATA_W-1:0] hold_reset(int win);
    return (win == 12 || win == 13) ? HOLD_PRESET : '0;
  endfunction
endpackage

// File: rtl/irqc_rst_sync.sv
`timescale 1ns/1ps
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irqc_group.sv
`timescale 1ns/1ps
module irqc_group
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [LANE_W-1:0] src_i,
  output logic [LANE_W-1:0] mask_o,
  output logic              irq_o
);
  logic [LANE_W-1:0] mask_q, mask_d;
  logic              irq_q, irq_d;
  logic              mask_ce;

  always_comb begin
    mask_ce = set_en | clr_en;
    mask_d  = mask_q;
    if (set_en)      mask_d = mask_q | lane_i;
    else if (clr_en) mask_d = mask_q & ~lane_i;
    irq_d = |(mask_d & src_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_ce) mask_q <= mask_d;
      irq_q <= irq_d;
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  // R2: every bit written as one is present after the set write
  p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((mask_q & $past(lane_i)) == $past(lane_i)));

  // R3: every bit written as one is gone after the clear write
  p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((mask_q & $past(lane_i)) == '0));

  // R2: the mask only moves on a set or clear write
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(mask_q));

  // R6: an asserted output always has some enabled bit behind it
  p_out_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (mask_q != '0));
endmodule

// File: rtl/irqc_window.sv
`timescale 1ns/1ps
module irqc_window
  import irqc_pkg::*;
#(
  parameter int WIN        = 0,
  parameter int SRC_GROUPS = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set_en,
  input  logic                   clr_en,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [DATA_W-1:0]      src_i,
  output logic [DATA_W-1:0]      hold_set_o,
  output logic [DATA_W-1:0]      hold_clr_o,
  output logic [DATA_W-1:0]      raw_o,
  output logic [DATA_W-1:0]      masked_o,
  output logic [GRP_PER_WIN-1:0] irq_o
);
  localparam logic [DATA_W-1:0] RST_V = hold_reset(WIN);

  logic [DATA_W-1:0] hset_q, hclr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hset_q <= RST_V;
      hclr_q <= RST_V;
    end else begin
      if (set_en) hset_q <= wdata_i;
      if (clr_en) hclr_q <= wdata_i;
    end
  end

  assign hold_set_o = hset_q;
  assign hold_clr_o = hclr_q;

  for (genvar k = 0; k < GRP_PER_WIN; k++) begin : g_lane
    localparam int GIDX = WIN * GRP_PER_WIN + k;
    logic [LANE_W-1:0] pend;
    logic [LANE_W-1:0] mask;

    if (GIDX < SRC_GROUPS) begin : g_live
      assign pend = src_i[LANE_W*k +: LANE_W];
    end else begin : g_dead
      logic unused_src;
      assign unused_src = ^src_i[LANE_W*k +: LANE_W];
      assign pend = '0;
    end

    irqc_group i_group (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (set_en),
      .clr_en (clr_en),
      .lane_i (wdata_i[LANE_W*k +: LANE_W]),
      .src_i  (pend),
      .mask_o (mask),
      .irq_o  (irq_o[k])
    );

    assign raw_o[LANE_W*k +: LANE_W]    = pend;
    assign masked_o[LANE_W*k +: LANE_W] = pend & mask;
  end

  // R8: a holder changes only on its own write
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !set_en |=> $stable(hset_q));
endmodule

// File: rtl/irqc_decode.sv
`timescale 1ns/1ps
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int NUM_WIN = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  output logic [3:0]         win_o,
  output word_e              word_o,
  output logic               in_win_o,
  output logic               in_sum_o,
  output logic [NUM_WIN-1:0] set_vec_o,
  output logic [NUM_WIN-1:0] clr_vec_o,
  output logic               bad_o
);
  localparam logic [4:0] NUM_WIN_L = 5'(NUM_WIN);

  logic bad_d, bad_q;

  always_comb begin
    win_o    = addr_i[7:4];
    word_o   = word_e'(addr_i[3:2]);
    in_win_o = !addr_i[8] && ({1'b0, addr_i[7:4]} < NUM_WIN_L);
    in_sum_o = (addr_i[8:3] == 6'b100000);
    for (int w = 0; w < NUM_WIN; w++) begin
      set_vec_o[w] = wr_i && in_win_o && (word_o == W_SET) && (addr_i[7:4] == 4'(w));
      clr_vec_o[w] = wr_i && in_win_o && (word_o == W_CLR) && (addr_i[7:4] == 4'(w));
    end
    bad_d = wr_i && ((in_win_o && addr_i[3]) || in_sum_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_q <= 1'b0;
    else        bad_q <= bad_d;
  end

  assign bad_o = bad_q;

  // R9: the flag never rises without a write in the cycle before
  p_bad_needs_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q |-> $past(wr_i));

  // R2: one write reaches at most one mask word
  p_single_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_vec_o, clr_vec_o}));
endmodule

// File: rtl/irq_combiner_top.sv
`timescale 1ns/1ps
module irq_combiner_top
  import irqc_pkg::*;
#(
  parameter int NUM_GROUPS = 64,
  parameter int SRC_GROUPS = 48
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_GROUPS*LANE_W-1:0] src_i,
  input  logic [ADDR_W-1:0]            bus_addr_i,
  input  logic                         bus_wr_i,
  input  logic [DATA_W-1:0]            bus_wdata_i,
  output logic [DATA_W-1:0]            bus_rdata_o,
  output logic [NUM_GROUPS-1:0]        irq_o,
  output logic                         bad_wr_o
);
  localparam int NUM_WIN = NUM_GROUPS / GRP_PER_WIN;
  localparam int WIN_W   = $clog2(NUM_WIN);

  logic               rst_sync_n;
  logic [3:0]         win;
  word_e              word;
  logic               in_win, in_sum;
  logic [NUM_WIN-1:0] set_vec, clr_vec;
  logic [DATA_W-1:0]  hs_a [NUM_WIN];
  logic [DATA_W-1:0]  hc_a [NUM_WIN];
  logic [DATA_W-1:0]  raw_a [NUM_WIN];
  logic [DATA_W-1:0]  msk_a [NUM_WIN];
  logic [63:0]        sum_vec;
  logic [WIN_W-1:0]   widx;

  irqc_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irqc_decode #(.NUM_WIN(NUM_WIN)) i_decode (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .addr_i    (bus_addr_i),
    .wr_i      (bus_wr_i),
    .win_o     (win),
    .word_o    (word),
    .in_win_o  (in_win),
    .in_sum_o  (in_sum),
    .set_vec_o (set_vec),
    .clr_vec_o (clr_vec),
    .bad_o     (bad_wr_o)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    irqc_window #(.WIN(w), .SRC_GROUPS(SRC_GROUPS)) i_window (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .set_en     (set_vec[w]),
      .clr_en     (clr_vec[w]),
      .wdata_i    (bus_wdata_i),
      .src_i      (src_i[w*DATA_W +: DATA_W]),
      .hold_set_o (hs_a[w]),
      .hold_clr_o (hc_a[w]),
      .raw_o      (raw_a[w]),
      .masked_o   (msk_a[w]),
      .irq_o      (irq_o[w*GRP_PER_WIN +: GRP_PER_WIN])
    );
  end

  always_comb begin
    sum_vec = '0;
    sum_vec[NUM_GROUPS-1:0] = irq_o;
  end

  assign widx = win[WIN_W-1:0];

  always_comb begin
    bus_rdata_o = '0;
    if (in_win) begin
      unique case (word)
        W_SET: bus_rdata_o = hs_a[widx];
        W_CLR: bus_rdata_o = hc_a[widx];
        W_RAW: bus_rdata_o = raw_a[widx];
        W_MSK: bus_rdata_o = msk_a[widx];
        default: bus_rdata_o = '0;
      endcase
    end else if (in_sum) begin
      bus_rdata_o = bus_addr_i[2] ? sum_vec[63:32] : sum_vec[31:0];
    end
  end

  // R9: writes to the mask words never raise the flag
  p_mask_write_no_bad_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr_i && in_win && !bus_addr_i[3]) |=> !bad_wr_o);

  // R11: unmapped offsets read zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!in_win && !in_sum) |-> (bus_rdata_o == '0));
endmodule

// File: tb/test_irq_combiner_top.sv
`timescale 1ns/1ps
module test_irq_combiner_top;
  localparam int NG    = 64;
  localparam int SRC_G = 48;
  localparam int NW    = NG / 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NG*8-1:0] src;
  logic [8:0]      addr;
  logic            wr;
  logic [31:0]     wdata;
  logic [31:0]     rdata;
  logic [NG-1:0]   irq;
  logic            bad;

  int checks = 0;
  int errors = 0;

  logic [7:0]    mask_m [NG];
  logic [31:0]   hs_m [NW];
  logic [31:0]   hc_m [NW];
  logic [NG-1:0] out_m;
  logic          bad_m;

  always #5 clk = ~clk;

  irq_combiner_top #(.NUM_GROUPS(NG), .SRC_GROUPS(SRC_G)) i_irq_combiner_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src),
    .bus_addr_i  (addr),
    .bus_wr_i    (wr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq),
    .bad_wr_o    (bad)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (addr %h)", tag, act, exp, addr);
    end
  endtask

  function automatic logic [7:0] pend_m(int g);
    return (g < SRC_G) ? src[g*8 +: 8] : 8'h00;
  endfunction

  function automatic logic [31:0] exp_read(logic [8:0] a);
    logic [31:0] v = '0;
    int w = int'(a[7:4]);
    if (!a[8]) begin
      case (a[3:2])
        2'd0: v = hs_m[w];
        2'd1: v = hc_m[w];
        2'd2: for (int k = 0; k < 4; k++) v[k*8 +: 8] = pend_m(w*4+k);
        default: for (int k = 0; k < 4; k++) v[k*8 +: 8] = pend_m(w*4+k) & mask_m[w*4+k];
      endcase
    end else if (a[8:3] == 6'b100000) begin
      v = a[2] ? out_m[63:32] : out_m[31:0];
    end
    return v;
  endfunction

  function automatic string region_tag(logic [8:0] a);
    if (!a[8]) begin
      case (a[3:2])
        2'd0, 2'd1: return "R8";
        2'd2:       return "R4";
        default:    return "R5";
      endcase
    end
    if (a[8:3] == 6'b100000) return "R7";
    return "R11";
  endfunction

  // Reference step taken at each rising edge: write first, then levels.
  task automatic model_edge();
    int w = int'(addr[7:4]);
    bad_m = 1'b0;
    if (wr) begin
      if (!addr[8]) begin
        case (addr[3:2])
          2'd0: begin
            hs_m[w] = wdata;
            for (int k = 0; k < 4; k++) mask_m[w*4+k] = mask_m[w*4+k] | wdata[k*8 +: 8];
          end
          2'd1: begin
            hc_m[w] = wdata;
            for (int k = 0; k < 4; k++) mask_m[w*4+k] = mask_m[w*4+k] & ~wdata[k*8 +: 8];
          end
          default: bad_m = 1'b1;
        endcase
      end else if (addr[8:3] == 6'b100000) begin
        bad_m = 1'b1;
      end
    end
    for (int g = 0; g < NG; g++) out_m[g] = |(mask_m[g] & pend_m(g));
  endtask

  // Called at a falling edge with inputs already driven.
  task automatic cyc();
    #1;
    chk(region_tag(addr), {32'h0, rdata}, {32'h0, exp_read(addr)});
    @(posedge clk);
    #1;
    model_edge();
    @(negedge clk);
    chk("R6", {{(64-NG){1'b0}}, irq}, {{(64-NG){1'b0}}, out_m});
    chk("R9", {63'h0, bad}, {63'h0, bad_m});
  endtask

  task automatic do_write(logic [8:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    cyc();
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_tag(logic [8:0] a, string tag);
    addr = a;
    #1;
    chk(tag, {32'h0, rdata}, {32'h0, exp_read(a)});
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src = '0; addr = '0; wr = 1'b0; wdata = '0;
    for (int g = 0; g < NG; g++) mask_m[g] = '0;
    for (int w = 0; w < NW; w++) begin hs_m[w] = '0; hc_m[w] = '0; end
    hs_m[12] = 32'h0101_0101; hc_m[12] = 32'h0101_0101;
    hs_m[13] = 32'h0101_0101; hc_m[13] = 32'h0101_0101;
    out_m = '0; bad_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cyc();

    // Reset state of holders and masks
    rd_tag(9'h0C0, "R8");
    rd_tag(9'h0D4, "R8");
    rd_tag(9'h0C8, "R8");
    rd_tag(9'h000, "R8");
    src = '1;
    rd_tag(9'h00C, "R11");
    rd_tag(9'h03C, "R11");
    cyc();
    chk("R11", {{(64-NG){1'b0}}, irq}, 64'h0);
    src = '0;
    cyc();

    // Mapping of one line: n=19 is group 2 bit 3, lane 2 of window 0
    src[19] = 1'b1;
    rd_tag(9'h008, "R1");
    chk("R1", {32'h0, rdata}, 64'h0000_0000_0008_0000);
    cyc();
    // Level not latched
    src[19] = 1'b0;
    rd_tag(9'h008, "R4");
    cyc();

    // Set then OR more bits
    src[19] = 1'b1;
    do_write(9'h000, 32'h0008_0000);
    chk("R2", {63'h0, irq[2]}, 64'h1);
    do_write(9'h000, 32'h0001_0000);
    src[16] = 1'b1;
    rd_tag(9'h00C, "R2");
    chk("R2", {32'h0, rdata}, 64'h0000_0000_0009_0000);
    cyc();

    // Clear one bit, the other stays
    do_write(9'h004, 32'h0008_0000);
    rd_tag(9'h00C, "R3");
    chk("R3", {32'h0, rdata}, 64'h0000_0000_0001_0000);
    rd_tag(9'h004, "R8");
    do_write(9'h004, 32'h0001_0000);
    chk("R3", {63'h0, irq[2]}, 64'h0);
    src = '0;
    cyc();

    // Group 50 above the source limit
    src[50*8+1] = 1'b1;
    do_write(9'h0C0, 32'h0002_0000);
    rd_tag(9'h0C8, "R10");
    chk("R10", {32'h0, rdata}, 64'h0);
    cyc();
    chk("R10", {63'h0, irq[50]}, 64'h0);
    src = '0;
    do_write(9'h0C4, 32'h0002_0000);

    // Writes to read-only places
    src[5] = 1'b1;
    do_write(9'h000, 32'h0000_0020);
    do_write(9'h008, 32'hFFFF_FFFF);
    rd_tag(9'h008, "R9");
    do_write(9'h00C, 32'h0);
    rd_tag(9'h00C, "R9");
    do_write(9'h100, 32'h0);
    rd_tag(9'h100, "R9");
    do_write(9'h104, 32'hFFFF_FFFF);
    cyc();
    chk("R9", {63'h0, bad}, 64'h0);

    // Summary words
    src[33*8] = 1'b1;
    do_write(9'h080, 32'h0000_0100);
    rd_tag(9'h100, "R7");
    rd_tag(9'h104, "R7");
    chk("R7", {32'h0, rdata}, 64'h2);
    cyc();

    // Unmapped
    rd_tag(9'h108, "R11");
    rd_tag(9'h1F0, "R11");
    cyc();

    // Write and level change in the same edge
    addr = 9'h010; wdata = 32'h0000_0400; wr = 1'b1; src[42] = 1'b1;
    cyc();
    wr = 1'b0;
    chk("R6", {63'h0, irq[5]}, 64'h1);
    addr = 9'h014; wdata = 32'h0000_0400; wr = 1'b1; src[42] = 1'b0;
    cyc();
    wr = 1'b0;
    chk("R6", {63'h0, irq[5]}, 64'h0);

    // Random phase
    for (int n = 0; n < 1500; n++) begin
      if ($urandom_range(0, 3) == 0)
        for (int i = 0; i < NG/4; i++) src[i*32 +: 32] = $urandom & $urandom & $urandom;
      if ($urandom_range(0, 2) == 0) begin
        wr = 1'b1;
        wdata = $urandom & $urandom;
        addr = {1'b0, 4'($urandom_range(0, NW-1)), 2'($urandom_range(0, 3)), 2'b00};
        if ($urandom_range(0, 15) == 0) addr = 9'h100 | 9'($urandom_range(0, 1) * 4);
      end else begin
        wr = 1'b0;
        wdata = '0;
        case ($urandom_range(0, 9))
          0: addr = 9'h100;
          1: addr = 9'h104;
          2: addr = 9'h108 + 9'($urandom_range(0, 60) * 4);
          default: addr = {1'b0, 8'($urandom_range(0, 63) * 4)};
        endcase
      end
      cyc();
    end
    wr = 1'b0;
    cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule